// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps an 80-bit time-of-day value for precision time stamping. The value is split into a 16-bit high-seconds extension, a 32-bit seconds count and a 32-bit nanoseconds count. On every cycle of the timer clock, the nanoseconds count grows by an 8-bit increment. That increment is set to the timer clock period expressed in nanosecond units.

A mode input picks how the nanoseconds count rolls over. In decimal mode it rolls over at one billion, so it holds true nanoseconds. In binary mode it rolls over at 2^31, so one unit is about 0.466 ns. A rollover carries into the seconds count. When the seconds count wraps, the carry goes into the high-seconds count. The same wrap sets a sticky overflow flag and raises a one-cycle interrupt pulse.

A load strobe sets all three time fields at once, for example when the time is first set.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset, all three time fields are zero, and the overflow flag and the interrupt are low.
- R2: In each cycle without a load, the nanoseconds field grows by the 8-bit `incr_i`. An increment of zero leaves all three fields unchanged.
- R3: Decimal mode is selected by `bin_mode_i`=0. When the nanoseconds field plus the increment reaches 1,000,000,000 or more, the nanoseconds field becomes that sum minus 1,000,000,000 and the seconds field grows by one.
- R4: Binary mode is selected by `bin_mode_i`=1. When the nanoseconds field plus the increment reaches 2^31 or more, the nanoseconds field becomes that sum minus 2^31 and the seconds field grows by one.
- R5: When the seconds field wraps from 0xFFFFFFFF to 0, the high-seconds field grows by one. The high-seconds field itself wraps from 0xFFFF to 0.
- R6: A seconds wrap sets `ovf_flag_o` and raises `ovf_irq_o` for exactly one cycle. Both appear in the same cycle as the wrapped seconds value.
- R7: `ovf_clr_i`=1 clears the overflow flag on the next clock and has no effect on the time. If a new wrap happens in the same cycle as the clear, the flag stays set.
- R8: `load_i`=1 copies the load inputs into all three fields on the next clock. In that cycle the increment is not applied, and the load never raises the overflow flag or the interrupt.
- R9: A loaded nanoseconds value above the mode's maximum is clamped to that maximum. The maximum is 0x3B9AC9FF in decimal mode and 0x7FFFFFFF in binary mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bin_mode_i | input | 1 | 1 selects binary rollover, 0 selects decimal rollover |
| incr_i | input | 8 | Nanosecond units added per clock |
| load_i | input | 1 | Load strobe for all three time fields |
| load_hi_i | input | 16 | High-seconds value to load |
| load_sec_i | input | 32 | Seconds value to load |
| load_ns_i | input | 32 | Nanoseconds value to load (clamped) |
| ovf_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| hi_sec_o | output | 16 | High-seconds field |
| sec_o | output | 32 | Seconds field |
| ns_o | output | 32 | Nanoseconds field |
| ovf_flag_o | output | 1 | Sticky seconds-overflow flag |
| ovf_irq_o | output | 1 | One-cycle seconds-overflow interrupt pulse |

## Verification
Every internal register of this block is an output port. A wrong next value therefore shows up at the ports on the very next clock edge.

A bad rollover modulus or a lost remainder only shows up in the cycle that crosses the boundary. The tests load values a few units below each modulus, so that the crossing happens within one or two clocks.

A carry chain fault between seconds and high seconds shows nothing until the seconds count wraps. Loading 0xFFFFFFFF brings that wrap to the next rollover.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
    localparam int TOD_HI_W  = 16;
    localparam int TOD_SEC_W = 32;
    localparam int TOD_NS_W  = 32;
    localparam int TOD_INC_W = 8;

    localparam logic [TOD_NS_W-1:0] DEC_MODULUS = TOD_NS_W'(1000000000);
    localparam logic [TOD_NS_W-1:0] BIN_MODULUS = TOD_NS_W'(64'h8000_0000);

    typedef struct packed {
        logic [TOD_HI_W-1:0]  hi;
        logic [TOD_SEC_W-1:0] sec;
        logic [TOD_NS_W-1:0]  ns;
        logic                 ovf_flag;
        logic                 ovf_irq;
    } tod_state_t;
endpackage

// File: rtl/ptp_tod_ns_step.sv
module ptp_tod_ns_step
    import ptp_tod_pkg::*;
#(
    parameter int NS_W  = TOD_NS_W,
    parameter int INC_W = TOD_INC_W
) (
    input  logic [NS_W-1:0]  ns_q,
    input  logic [INC_W-1:0] incr,
    input  logic             bin_mode,
    input  logic             load,
    input  logic [NS_W-1:0]  load_ns,
    output logic [NS_W-1:0]  ns_d,
    output logic             carry
);
    localparam int SUM_W = NS_W + 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] modulus;
    logic [NS_W-1:0]  max_ns;

    always_comb begin
        modulus = bin_mode ? {1'b0, BIN_MODULUS} : {1'b0, DEC_MODULUS};
        max_ns  = modulus[NS_W-1:0] - NS_W'(1);
        sum     = {1'b0, ns_q} + SUM_W'(incr);
        carry   = 1'b0;
        ns_d    = sum[NS_W-1:0];
        if (load) begin
            ns_d = (load_ns > max_ns) ? max_ns : load_ns;
        end else if (sum >= modulus) begin
            ns_d  = NS_W'(sum - modulus);
            carry = 1'b1;
        end
    end
endmodule

// File: rtl/ptp_tod_sec_step.sv
module ptp_tod_sec_step
    import ptp_tod_pkg::*;
#(
    parameter int SEC_W = TOD_SEC_W,
    parameter int HI_W  = TOD_HI_W
) (
    input  logic [SEC_W-1:0] sec_q,
    input  logic [HI_W-1:0]  hi_q,
    input  logic             carry,
    input  logic             load,
    input  logic [SEC_W-1:0] load_sec,
    input  logic [HI_W-1:0]  load_hi,
    output logic [SEC_W-1:0] sec_d,
    output logic [HI_W-1:0]  hi_d,
    output logic             wrap
);
    always_comb begin
        sec_d = sec_q;
        hi_d  = hi_q;
        wrap  = 1'b0;
        if (load) begin
            sec_d = load_sec;
            hi_d  = load_hi;
        end else if (carry) begin
            sec_d = sec_q + SEC_W'(1);
            if (&sec_q) begin
                wrap = 1'b1;
                hi_d = hi_q + HI_W'(1);
            end
        end
    end
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
    import ptp_tod_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bin_mode_i,
    input  logic [TOD_INC_W-1:0] incr_i,
    input  logic                 load_i,
    input  logic [TOD_HI_W-1:0]  load_hi_i,
    input  logic [TOD_SEC_W-1:0] load_sec_i,
    input  logic [TOD_NS_W-1:0]  load_ns_i,
    input  logic                 ovf_clr_i,
    output logic [TOD_HI_W-1:0]  hi_sec_o,
    output logic [TOD_SEC_W-1:0] sec_o,
    output logic [TOD_NS_W-1:0]  ns_o,
    output logic                 ovf_flag_o,
    output logic                 ovf_irq_o
);
    tod_state_t st_d, st_q;

    logic [TOD_NS_W-1:0]  ns_next;
    logic [TOD_SEC_W-1:0] sec_next;
    logic [TOD_HI_W-1:0]  hi_next;
    logic                 ns_carry;
    logic                 sec_wrap;

    ptp_tod_ns_step #(.NS_W(TOD_NS_W), .INC_W(TOD_INC_W)) ns_step_i (
        .ns_q     (st_q.ns),
        .incr     (incr_i),
        .bin_mode (bin_mode_i),
        .load     (load_i),
        .load_ns  (load_ns_i),
        .ns_d     (ns_next),
        .carry    (ns_carry)
    );

    ptp_tod_sec_step #(.SEC_W(TOD_SEC_W), .HI_W(TOD_HI_W)) sec_step_i (
        .sec_q    (st_q.sec),
        .hi_q     (st_q.hi),
        .carry    (ns_carry),
        .load     (load_i),
        .load_sec (load_sec_i),
        .load_hi  (load_hi_i),
        .sec_d    (sec_next),
        .hi_d     (hi_next),
        .wrap     (sec_wrap)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ns       = ns_next;
        st_d.sec      = sec_next;
        st_d.hi       = hi_next;
        st_d.ovf_irq  = sec_wrap;
        st_d.ovf_flag = sec_wrap | (st_q.ovf_flag & ~ovf_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi_sec_o   = st_q.hi;
    assign sec_o      = st_q.sec;
    assign ns_o       = st_q.ns;
    assign ovf_flag_o = st_q.ovf_flag;
    assign ovf_irq_o  = st_q.ovf_irq;
endmodule

// File: rtl/ptp_tod_counter_chk.sv
module ptp_tod_counter_chk
    import ptp_tod_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bin_mode_i,
    input logic [TOD_INC_W-1:0] incr_i,
    input logic                 load_i,
    input logic                 ovf_clr_i,
    input logic [TOD_HI_W-1:0]  hi_sec_o,
    input logic [TOD_SEC_W-1:0] sec_o,
    input logic [TOD_NS_W-1:0]  ns_o,
    input logic                 ovf_flag_o,
    input logic                 ovf_irq_o
);
    localparam logic [TOD_NS_W-1:0] DEC_MAX = DEC_MODULUS - TOD_NS_W'(1);
    localparam logic [TOD_NS_W-1:0] BIN_MAX = BIN_MODULUS - TOD_NS_W'(1);

    assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && incr_i == '0) |=> ($stable(ns_o) && $stable(sec_o) && $stable(hi_sec_o)));

    assert_dec_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !bin_mode_i && ns_o <= DEC_MAX) |=> (ns_o <= DEC_MAX));

    assert_bin_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && bin_mode_i && ns_o <= BIN_MAX) |=> (ns_o <= BIN_MAX));

    assert_hi_only_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ((hi_sec_o != $past(hi_sec_o)) == ovf_irq_o));

    assert_irq_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq_o |-> ovf_flag_o);

    assert_irq_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq_o |=> !ovf_irq_o);

    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr_i && !ovf_irq_o) |=> (ovf_flag_o == ovf_irq_o));

    assert_load_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !ovf_irq_o);

    assert_load_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !bin_mode_i) |=> (ns_o <= DEC_MAX));

    assert_sec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (sec_o == $past(sec_o) || sec_o == $past(sec_o) + 32'd1));
endmodule

bind ptp_tod_counter ptp_tod_counter_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bin_mode_i (bin_mode_i),
    .incr_i     (incr_i),
    .load_i     (load_i),
    .ovf_clr_i  (ovf_clr_i),
    .hi_sec_o   (hi_sec_o),
    .sec_o      (sec_o),
    .ns_o       (ns_o),
    .ovf_flag_o (ovf_flag_o),
    .ovf_irq_o  (ovf_irq_o)
);

// File: tb/ptp_tod_counter_tb.sv
module ptp_tod_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bin_mode_i = 1'b0;
    logic [7:0]  incr_i = '0;
    logic        load_i = 1'b0;
    logic [15:0] load_hi_i = '0;
    logic [31:0] load_sec_i = '0;
    logic [31:0] load_ns_i = '0;
    logic        ovf_clr_i = 1'b0;
    logic [15:0] hi_sec_o;
    logic [31:0] sec_o;
    logic [31:0] ns_o;
    logic        ovf_flag_o;
    logic        ovf_irq_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ptp_tod_counter dut_i (
        .clk(clk), .rst_n(rst_n), .bin_mode_i(bin_mode_i), .incr_i(incr_i),
        .load_i(load_i), .load_hi_i(load_hi_i), .load_sec_i(load_sec_i),
        .load_ns_i(load_ns_i), .ovf_clr_i(ovf_clr_i), .hi_sec_o(hi_sec_o),
        .sec_o(sec_o), .ns_o(ns_o), .ovf_flag_o(ovf_flag_o), .ovf_irq_o(ovf_irq_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic load_time(input logic [15:0] hi, input logic [31:0] sec,
                             input logic [31:0] ns);
        load_i = 1'b1; load_hi_i = hi; load_sec_i = sec; load_ns_i = ns;
        tick(1);
        load_i = 1'b0;
    endtask

    task automatic test_reset;
        check("R1", "hi", 32'(hi_sec_o), 0);
        check("R1", "sec", sec_o, 0);
        check("R1", "ns", ns_o, 0);
        check("R1", "flag", 32'(ovf_flag_o), 0);
        check("R1", "irq", 32'(ovf_irq_o), 0);
    endtask

    task automatic test_increment;
        bin_mode_i = 1'b0; incr_i = 8'd0;
        load_time(16'h0, 32'd0, 32'd0);
        incr_i = 8'd8;
        tick(10);
        check("R2", "ns after 10x8", ns_o, 32'd80);
        incr_i = 8'd255;
        tick(2);
        check("R2", "ns after 2x255", ns_o, 32'd590);
        incr_i = 8'd0;
        tick(3);
        check("R2", "ns frozen", ns_o, 32'd590);
        check("R2", "sec frozen", sec_o, 32'd0);
    endtask

    task automatic test_decimal;
        bin_mode_i = 1'b0; incr_i = 8'd0;
        load_time(16'h0, 32'd5, 32'd999999991);
        incr_i = 8'd8;
        tick(1);
        check("R3", "ns at max no roll", ns_o, 32'd999999999);
        check("R3", "sec no roll", sec_o, 32'd5);
        tick(1);
        check("R3", "ns remainder", ns_o, 32'd7);
        check("R3", "sec rolled", sec_o, 32'd6);
        incr_i = 8'd0;
        load_time(16'h0, 32'd9, 32'd999999992);
        incr_i = 8'd8;
        tick(1);
        incr_i = 8'd0;
        check("R3", "ns exact boundary", ns_o, 32'd0);
        check("R3", "sec exact boundary", sec_o, 32'd10);
    endtask

    task automatic test_binary;
        bin_mode_i = 1'b1; incr_i = 8'd0;
        load_time(16'h0, 32'd3, 32'h7FFF_FFFA);
        incr_i = 8'd10;
        tick(1);
        incr_i = 8'd0;
        check("R4", "ns remainder", ns_o, 32'd4);
        check("R4", "sec rolled", sec_o, 32'd4);
        load_time(16'h0, 32'd3, 32'h3B9A_CA05);
        incr_i = 8'd10;
        tick(1);
        incr_i = 8'd0;
        check("R4", "no roll past 1e9", ns_o, 32'h3B9A_CA0F);
        check("R4", "sec kept", sec_o, 32'd3);
        bin_mode_i = 1'b0;
    endtask

    task automatic test_sec_wrap;
        bin_mode_i = 1'b0; incr_i = 8'd0;
        load_time(16'h0007, 32'hFFFF_FFFF, 32'd999999999);
        check("R8", "no irq on load", 32'(ovf_irq_o), 0);
        incr_i = 8'd1;
        tick(1);
        incr_i = 8'd0;
        check("R5", "sec wrapped", sec_o, 32'd0);
        check("R5", "hi incremented", 32'(hi_sec_o), 32'h8);
        check("R6", "irq raised", 32'(ovf_irq_o), 1);
        check("R6", "flag set", 32'(ovf_flag_o), 1);
        tick(1);
        check("R6", "irq one cycle", 32'(ovf_irq_o), 0);
        check("R6", "flag sticky", 32'(ovf_flag_o), 1);
    endtask

    task automatic test_clear;
        incr_i = 8'd0;
        ovf_clr_i = 1'b1;
        tick(1);
        ovf_clr_i = 1'b0;
        check("R7", "flag cleared", 32'(ovf_flag_o), 0);
        check("R7", "hi untouched", 32'(hi_sec_o), 32'h8);
        check("R7", "ns untouched", ns_o, 32'd0);
        load_time(16'hFFFF, 32'hFFFF_FFFF, 32'd999999998);
        incr_i = 8'd2; ovf_clr_i = 1'b1;
        tick(1);
        incr_i = 8'd0; ovf_clr_i = 1'b0;
        check("R7", "set wins over clear", 32'(ovf_flag_o), 1);
        check("R5", "hi wraps to 0", 32'(hi_sec_o), 32'h0);
    endtask

    task automatic test_load;
        bin_mode_i = 1'b0; incr_i = 8'd50;
        load_time(16'h1234, 32'hCAFE_0001, 32'd12345);
        check("R8", "load hi", 32'(hi_sec_o), 32'h1234);
        check("R8", "load sec", sec_o, 32'hCAFE_0001);
        check("R8", "load ns no incr", ns_o, 32'd12345);
        incr_i = 8'd0;
        load_time(16'h0, 32'd0, 32'hFFFF_FFFF);
        check("R9", "decimal clamp", ns_o, 32'h3B9A_C9FF);
        bin_mode_i = 1'b1;
        load_time(16'h0, 32'd0, 32'hFFFF_FFFF);
        check("R9", "binary clamp", ns_o, 32'h7FFF_FFFF);
        bin_mode_i = 1'b0;
    endtask

    initial begin
        #1;
        check("R1", "ns during reset", ns_o, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_increment();
        test_decimal();
        test_binary();
        test_sec_wrap();
        test_clear();
        test_load();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #20000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule